// File: doc/BRIEF.md
# Ownership, Start and Status Control for a Command List Processor

This block decides who owns a command list processor, when its sequencer is allowed to run and how the run ends. A host claims the module with a test-and-set booking command: the first claim after power-up succeeds and answers Q = 1, every later claim answers Q = 0, so a second controller learns the module is taken. Until the module is claimed, every status or control access is refused with Q = 0 and has no effect.

Once claimed, the sequencer is started in one of three ways. The host can write the run bit of the status word. Any of seven external trigger inputs can start it. A separately selectable external attention input can also start it. The triggers and the attention input take effect only when triggering has been enabled. The inputs are synchronised and edge-detected. The number of the trigger that started the current run is shown in binary on three indicator outputs. When the sequencer reports a stop, the run bit falls and a flag records the cause: normal finish, missing Q or missing X. While any flag is set an attention request is raised. The host clears a flag by writing 0 to its bit.

Top module: `lp_book_lam`

## Requirements
- R1: After reset the module is unbooked, the status word reads 0, `trig_code` is 0, `lam_req` is 0 and no start pulse is issued.
- R2: The booking command (function 27, subaddress 0) answers Q = 1 if the module was unbooked and Q = 0 if it was already booked, and leaves it booked. Every command gets its response on `rsp_valid` exactly one cycle after `cmd_valid`.
- R3: A read (function 0) at subaddress 1 returns the status word with run at bit 4, finished at bit 3, no-Q at bit 2, no-X at bit 1 and bit 0 = 0. A read at subaddress 2 returns the trigger enable at bit 0 and the attention-source enable at bit 1.
- R4: While the module is unbooked, reads and writes (function 16) answer Q = 0 with data 0, change no state and start nothing. Once booked, they answer Q = 1.
- R5: A status write with bit 4 = 1 while the run bit is 0 sets the run bit and issues one `seq_start` pulse, one cycle after the command. `trig_code` is 0 for such a run.
- R6: With the trigger enable set, a rising edge on a trigger input starts a run. The run bit is set on the third clock edge after the input rises. With the trigger enable clear, trigger edges are ignored.
- R7: If several trigger inputs rise in the same cycle, the lowest-numbered one wins. `trig_code` shows its number, 1 to 7 (input bit index + 1), in binary.
- R8: A rising edge on `ext_lam_in` starts a run only when both the trigger enable and the attention-source enable are set. `trig_code` stays 0 for such a run.
- R9: `seq_stop` during a run clears the run bit and sets `trig_code` to 0. It sets the flag that `seq_stop_cause` selects: 0 = finished, 1 = no-Q, 2 = no-X.
- R10: A status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. Writing bit 4 = 0 does not clear the run bit.
- R11: `lam_req` is 1 exactly while at least one of the finished, no-Q or no-X flags is set.
- R12: Start requests (host, trigger or attention input) that arrive while the run bit is set are ignored: no `seq_start` pulse is issued and `trig_code` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe, one cycle |
| cmd_func | input | 5 | Command function code |
| cmd_sub | input | 4 | Command subaddress |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_q | output | 1 | Q response |
| rsp_rdata | output | DATA_W | Read data |
| trig_in | input | NUM_TRIG | Asynchronous external trigger inputs |
| ext_lam_in | input | 1 | Asynchronous external attention input used as a start source |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_stop | input | 1 | Stop report from the sequencer |
| seq_stop_cause | input | 2 | Stop cause: 0 finished, 1 no-Q, 2 no-X |
| trig_code | output | CODE_W | Number of the trigger that started the current run, 0 if none |
| lam_req | output | 1 | Attention request |

## Verification
Command responses are due one cycle after the strobe. The bench drives commands on a falling edge, and its monitor pops the expected response at the next falling edge that shows `rsp_valid`. Trigger and attention edges pass through two synchroniser stages and an edge register, so the bench checks `trig_code` on the third falling edge after driving the input. Ignored edges are checked after the same or a longer wait. Flag and `lam_req` effects of a stop are due one cycle after `seq_stop`. The bench always confirms them through a status read, counting start pulses away from the edge that creates them.

// File: rtl/lp_book_pkg.sv
package lp_book_pkg;

    localparam logic [4:0] FN_READ  = 5'd0;
    localparam logic [4:0] FN_WRITE = 5'd16;
    localparam logic [4:0] FN_BOOK  = 5'd27;
    localparam logic [3:0] SA_BOOK  = 4'd0;
    localparam logic [3:0] SA_STAT  = 4'd1;
    localparam logic [3:0] SA_CTRL  = 4'd2;

    localparam int BIT_RUN  = 4;
    localparam int BIT_FIN  = 3;
    localparam int BIT_NOQ  = 2;
    localparam int BIT_NOX  = 1;
    localparam int BIT_TEN  = 0;
    localparam int BIT_LEN  = 1;

    typedef enum logic [1:0] {
        STOP_DONE = 2'd0,
        STOP_NOQ  = 2'd1,
        STOP_NOX  = 2'd2
    } stop_cause_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BOOK,
        OP_RD_STAT,
        OP_WR_STAT,
        OP_RD_CTRL,
        OP_WR_CTRL
    } host_op_e;

    typedef struct packed {
        logic run;
        logic fin;
        logic noq;
        logic nox;
    } run_status_t;

    typedef struct packed {
        logic trig_en;
        logic lam_en;
    } start_ctrl_t;

    function automatic host_op_e decode_op(input logic [4:0] f, input logic [3:0] a);
        host_op_e op;
        op = OP_NONE;
        if (f == FN_BOOK && a == SA_BOOK)       op = OP_BOOK;
        else if (f == FN_READ && a == SA_STAT)  op = OP_RD_STAT;
        else if (f == FN_READ && a == SA_CTRL)  op = OP_RD_CTRL;
        else if (f == FN_WRITE && a == SA_STAT) op = OP_WR_STAT;
        else if (f == FN_WRITE && a == SA_CTRL) op = OP_WR_CTRL;
        return op;
    endfunction

endpackage

// File: rtl/lp_edge_sync.sv
module lp_edge_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/lp_start_arb.sv
module lp_start_arb #(
    parameter int NUM_TRIG = 7,
    parameter int CODE_W   = 3
) (
    input  logic                booked,
    input  logic                running,
    input  logic                host_go,
    input  lp_book_pkg::start_ctrl_t ctrl,
    input  logic [NUM_TRIG-1:0] trig_rise,
    input  logic                lam_rise,
    output logic                start,
    output logic [CODE_W-1:0]   start_code
);
    logic [CODE_W-1:0] lowest;
    logic              any_trig;

    always_comb begin
        lowest = '0;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (trig_rise[i]) lowest = CODE_W'(i + 1);
        end
    end

    assign any_trig = |trig_rise;

    always_comb begin
        start      = 1'b0;
        start_code = '0;
        if (booked && !running) begin
            if (host_go) begin
                start = 1'b1;
            end else if (ctrl.trig_en && any_trig) begin
                start      = 1'b1;
                start_code = lowest;
            end else if (ctrl.trig_en && ctrl.lam_en && lam_rise) begin
                start = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lp_cmd_decode.sv
module lp_cmd_decode #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_func,
    input  logic [3:0]        cmd_sub,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  lp_book_pkg::run_status_t status,
    output logic              booked,
    output lp_book_pkg::start_ctrl_t ctrl,
    output logic              stat_wr,
    output logic              rsp_valid,
    output logic              rsp_q,
    output logic [DATA_W-1:0] rsp_rdata
);
    import lp_book_pkg::*;

    host_op_e          op;
    logic              q_next;
    logic [DATA_W-1:0] rd_next;

    assign op      = cmd_valid ? decode_op(cmd_func, cmd_sub) : OP_NONE;
    assign stat_wr = (op == OP_WR_STAT) && booked;

    always_comb begin
        q_next  = 1'b0;
        rd_next = '0;
        unique case (op)
            OP_BOOK:    q_next = !booked;
            OP_WR_STAT,
            OP_WR_CTRL: q_next = booked;
            OP_RD_STAT: begin
                q_next = booked;
                if (booked) begin
                    rd_next[BIT_RUN] = status.run;
                    rd_next[BIT_FIN] = status.fin;
                    rd_next[BIT_NOQ] = status.noq;
                    rd_next[BIT_NOX] = status.nox;
                end
            end
            OP_RD_CTRL: begin
                q_next = booked;
                if (booked) begin
                    rd_next[BIT_TEN] = ctrl.trig_en;
                    rd_next[BIT_LEN] = ctrl.lam_en;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            booked    <= 1'b0;
            ctrl      <= '0;
            rsp_valid <= 1'b0;
            rsp_q     <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_q     <= q_next;
            rsp_rdata <= rd_next;
            if (op == OP_BOOK) booked <= 1'b1;
            if (op == OP_WR_CTRL && booked) begin
                ctrl.trig_en <= cmd_wdata[BIT_TEN];
                ctrl.lam_en  <= cmd_wdata[BIT_LEN];
            end
        end
    end
endmodule

// File: rtl/lp_status_reg.sv
module lp_status_reg #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] start_code,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stop,
    input  logic [1:0]        stop_cause,
    output lp_book_pkg::run_status_t status,
    output logic [CODE_W-1:0] code,
    output logic              start_pulse
);
    import lp_book_pkg::*;

    stop_cause_e cause;
    logic        stop_act;
    logic        set_fin, set_noq, set_nox;

    assign cause    = stop_cause_e'(stop_cause);
    assign stop_act = stop && status.run;
    assign set_fin  = stop_act && (cause == STOP_DONE);
    assign set_noq  = stop_act && (cause == STOP_NOQ);
    assign set_nox  = stop_act && (cause == STOP_NOX);

    always_ff @(posedge clk) begin
        if (rst) begin
            status      <= '0;
            code        <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= start;
            if (start) begin
                status.run <= 1'b1;
                code       <= start_code;
            end else if (stop_act) begin
                status.run <= 1'b0;
                code       <= '0;
            end
            if (set_fin)      status.fin <= 1'b1;
            else if (stat_wr) status.fin <= status.fin & wdata[BIT_FIN];
            if (set_noq)      status.noq <= 1'b1;
            else if (stat_wr) status.noq <= status.noq & wdata[BIT_NOQ];
            if (set_nox)      status.nox <= 1'b1;
            else if (stat_wr) status.nox <= status.nox & wdata[BIT_NOX];
        end
    end
endmodule

// File: rtl/lp_book_lam.sv
module lp_book_lam #(
    parameter int DATA_W   = 8,
    parameter int NUM_TRIG = 7,
    parameter int STAGES   = 2,
    localparam int CODE_W  = $clog2(NUM_TRIG + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [4:0]          cmd_func,
    input  logic [3:0]          cmd_sub,
    input  logic [DATA_W-1:0]   cmd_wdata,
    output logic                rsp_valid,
    output logic                rsp_q,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                ext_lam_in,
    output logic                seq_start,
    input  logic                seq_stop,
    input  logic [1:0]          seq_stop_cause,
    output logic [CODE_W-1:0]   trig_code,
    output logic                lam_req
);
    import lp_book_pkg::*;

    localparam int LANES = NUM_TRIG + 1;

    logic              booked;
    start_ctrl_t       ctrl;
    run_status_t       status;
    logic              stat_wr;
    logic              host_go;
    logic [LANES-1:0]  rise;
    logic              start;
    logic [CODE_W-1:0] start_code;

    lp_edge_sync #(.WIDTH(LANES), .STAGES(STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ext_lam_in, trig_in}),
        .rise     (rise)
    );

    lp_cmd_decode #(.DATA_W(DATA_W)) dec_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_func  (cmd_func),
        .cmd_sub   (cmd_sub),
        .cmd_wdata (cmd_wdata),
        .status    (status),
        .booked    (booked),
        .ctrl      (ctrl),
        .stat_wr   (stat_wr),
        .rsp_valid (rsp_valid),
        .rsp_q     (rsp_q),
        .rsp_rdata (rsp_rdata)
    );

    assign host_go = stat_wr && cmd_wdata[BIT_RUN];

    lp_start_arb #(.NUM_TRIG(NUM_TRIG), .CODE_W(CODE_W)) arb_i (
        .booked     (booked),
        .running    (status.run),
        .host_go    (host_go),
        .ctrl       (ctrl),
        .trig_rise  (rise[NUM_TRIG-1:0]),
        .lam_rise   (rise[NUM_TRIG]),
        .start      (start),
        .start_code (start_code)
    );

    lp_status_reg #(.DATA_W(DATA_W), .CODE_W(CODE_W)) stat_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_code  (start_code),
        .stat_wr     (stat_wr),
        .wdata       (cmd_wdata),
        .stop        (seq_stop),
        .stop_cause  (seq_stop_cause),
        .status      (status),
        .code        (trig_code),
        .start_pulse (seq_start)
    );

    assign lam_req = status.fin | status.noq | status.nox;
endmodule

// File: rtl/lp_book_lam_chk.sv
module lp_book_lam_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              rsp_valid,
    input logic              booked,
    input logic              running,
    input logic              seq_start,
    input logic              seq_stop,
    input logic              lam_req,
    input logic [CODE_W-1:0] trig_code
);
    p_rsp_latency_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    p_booked_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        booked |=> booked);

    p_start_needs_book_r4: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> booked);

    p_start_sets_run_r5: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> running);

    p_stop_ends_run_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_stop && running) |=> (!running && trig_code == '0));

    p_idle_code_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !running |-> (trig_code == '0));

    p_stop_raises_lam_r11: assert property (@(posedge clk) disable iff (rst)
        (seq_stop && running) |=> lam_req);

    p_no_restart_r12: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> !$past(running));
endmodule

bind lp_book_lam lp_book_lam_chk #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .rsp_valid (rsp_valid),
    .booked    (booked),
    .running   (status.run),
    .seq_start (seq_start),
    .seq_stop  (seq_stop),
    .lam_req   (lam_req),
    .trig_code (trig_code)
);

// File: tb/lp_book_lam_tb_top.sv
module lp_book_lam_tb_top;

    localparam int DW = 8;
    localparam int NT = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [4:0]    cmd_func  = '0;
    logic [3:0]    cmd_sub   = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid, rsp_q;
    logic [DW-1:0] rsp_rdata;
    logic [NT-1:0] trig_in = '0;
    logic          ext_lam_in = 1'b0;
    logic          seq_start;
    logic          seq_stop = 1'b0;
    logic [1:0]    seq_stop_cause = '0;
    logic [2:0]    trig_code;
    logic          lam_req;

    int checks = 0;
    int errors = 0;
    int starts = 0;

    typedef struct {
        bit        q;
        bit [7:0]  data;
        string     tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    lp_book_lam #(.DATA_W(DW), .NUM_TRIG(NT)) dut_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_func(cmd_func), .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_q(rsp_q), .rsp_rdata(rsp_rdata),
        .trig_in(trig_in), .ext_lam_in(ext_lam_in),
        .seq_start(seq_start), .seq_stop(seq_stop), .seq_stop_cause(seq_stop_cause),
        .trig_code(trig_code), .lam_req(lam_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every response is compared with the oldest expectation
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk("R2 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " q"}, int'(rsp_q), int'(e.q));
                chk({e.tag, " data"}, int'(rsp_rdata), int'(e.data));
            end
        end
        if (!rst && seq_start) starts++;
    end

    task automatic send(input logic [4:0] f, input logic [3:0] a, input logic [7:0] wd,
                        input bit eq, input bit [7:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; cmd_sub = a; cmd_wdata = wd;
        e.q = eq; e.data = ed; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic book(input bit eq, input string tag);
        send(5'd27, 4'd0, 8'h00, eq, 8'h00, tag);
    endtask
    task automatic rd_stat(input bit eq, input bit [7:0] ed, input string tag);
        send(5'd0, 4'd1, 8'h00, eq, ed, tag);
    endtask
    task automatic rd_ctrl(input bit eq, input bit [7:0] ed, input string tag);
        send(5'd0, 4'd2, 8'h00, eq, ed, tag);
    endtask
    task automatic wr_stat(input logic [7:0] wd, input bit eq, input string tag);
        send(5'd16, 4'd1, wd, eq, 8'h00, tag);
    endtask
    task automatic wr_ctrl(input logic [7:0] wd, input bit eq, input string tag);
        send(5'd16, 4'd2, wd, eq, 8'h00, tag);
    endtask

    // Drive inputs on a falling edge; return on the third falling edge after
    task automatic fire(input logic [NT-1:0] t, input logic l);
        @(negedge clk);
        trig_in = t; ext_lam_in = l;
        repeat (3) @(negedge clk);
    endtask

    task automatic release_all();
        @(negedge clk);
        trig_in = '0; ext_lam_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic stop(input logic [1:0] cause);
        @(negedge clk);
        seq_stop = 1'b1; seq_stop_cause = cause;
        @(negedge clk);
        seq_stop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 trig_code", int'(trig_code), 0);
        chk("R1 lam_req", int'(lam_req), 0);
        chk("R1 start pulses", starts, 0);

        // Accesses while unbooked are refused and have no effect
        rd_stat(1'b0, 8'h00, "R4 read unbooked");
        wr_ctrl(8'h03, 1'b0, "R4 ctrl write unbooked");
        wr_stat(8'h10, 1'b0, "R4 run write unbooked");
        @(negedge clk);
        chk("R4 no start while unbooked", starts, 0);

        book(1'b1, "R2 first booking");
        book(1'b0, "R2 second booking refused");
        rd_ctrl(1'b1, 8'h00, "R4 ctrl untouched by unbooked write");
        rd_stat(1'b1, 8'h00, "R1 status after booking");

        // Triggers disabled
        fire(7'b0000100, 1'b0);
        chk("R6 disabled trigger code", int'(trig_code), 0);
        release_all();
        rd_stat(1'b1, 8'h00, "R6 disabled trigger status");
        chk("R6 disabled trigger no start", starts, 0);

        // Host start
        wr_stat(8'h10, 1'b1, "R5 host run write");
        rd_stat(1'b1, 8'h10, "R5 run bit set");
        chk("R5 one start pulse", starts, 1);
        chk("R5 host run code", int'(trig_code), 0);
        wr_stat(8'h10, 1'b1, "R12 run write while running");
        chk("R12 no second pulse", starts, 1);
        wr_stat(8'h00, 1'b1, "R10 run write 0");
        rd_stat(1'b1, 8'h10, "R10 run bit kept");

        stop(2'd0);
        chk("R11 lam after finish", int'(lam_req), 1);
        chk("R9 code after stop", int'(trig_code), 0);
        rd_stat(1'b1, 8'h08, "R9 finished flag");

        // Trigger start, two at once
        wr_ctrl(8'h01, 1'b1, "R6 enable triggers");
        fire(7'b0100100, 1'b0);
        chk("R7 lowest trigger wins", int'(trig_code), 3);
        release_all();
        rd_stat(1'b1, 8'h18, "R6 trigger started run");
        chk("R6 trigger start pulse", starts, 2);

        fire(7'b0000001, 1'b0);
        chk("R12 code unchanged", int'(trig_code), 3);
        release_all();
        chk("R12 no pulse while running", starts, 2);

        stop(2'd1);
        rd_stat(1'b1, 8'h0C, "R9 no-Q flag");
        chk("R9 code cleared", int'(trig_code), 0);

        wr_stat(8'h04, 1'b1, "R10 clear finished");
        rd_stat(1'b1, 8'h04, "R10 no-Q kept");
        chk("R11 lam with no-Q", int'(lam_req), 1);
        wr_stat(8'h00, 1'b1, "R10 clear all");
        rd_stat(1'b1, 8'h00, "R10 flags clear");
        chk("R11 lam low", int'(lam_req), 0);

        // Attention input as a start source
        fire('0, 1'b1);
        release_all();
        rd_stat(1'b1, 8'h00, "R8 attention ignored without source enable");
        chk("R8 no start", starts, 2);
        wr_ctrl(8'h03, 1'b1, "R8 enable source");
        rd_ctrl(1'b1, 8'h03, "R3 ctrl read");
        fire('0, 1'b1);
        chk("R8 attention code", int'(trig_code), 0);
        release_all();
        rd_stat(1'b1, 8'h10, "R8 attention started run");
        chk("R8 start pulse", starts, 3);

        stop(2'd2);
        rd_stat(1'b1, 8'h02, "R9 no-X flag");

        fire(7'b1000000, 1'b0);
        chk("R7 highest trigger code", int'(trig_code), 7);
        release_all();
        stop(2'd0);
        rd_stat(1'b1, 8'h0A, "R3 status bit layout");
        chk("R9 code after stop", int'(trig_code), 0);
        chk("R6 start count", starts, 4);

        repeat (3) @(negedge clk);
        chk("R2 all responses seen", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule